// File: doc/BRIEF.md
# Dual-Phase Frame Word Serializer

The serializer turns parallel transmit words into a bit stream on one data line. A frame holds one or two phases. Each phase takes its own word-length code, which picks a width from a fixed set of 8, 12, 16, 20, 24 or 32 bits, and its own word count. A frame begins when a frame-sync pulse arrives in a bit-clock enable cycle while the block is idle. The block then sends every word of the first phase and, when the dual-phase bit is set, every word of the second phase. After that it idles until the next accepted frame sync.

Words come in over a 32-bit valid/ready handshake, and the block takes one word at each word start. When no word is offered at a word start, the block sends the previous word again and raises an underrun flag. A reserved length code is sent as an 8-bit word and raises an error flag. A word-boundary strobe marks the end of each word so that a downstream framer or a test harness can count words.

Top module: `frame_serializer`

## Requirements
- R1: While reset is asserted and after it is released, `sdata_o`, `sdata_oe_o`, `word_end_o`, `code_err_o` and `underrun_o` are all 0, and `data_ready_o` stays 0 while `bit_en_i` is 0.
- R2: Length code 0, 1, 2, 3, 4 and 5 selects a word of 8, 12, 16, 20, 24 and 32 bits. The word is the low N bits of `data_i`, sent most significant bit first, one bit per `bit_en_i` cycle.
- R3: Length codes 6 and 7 are reserved and are sent as 8-bit words. `code_err_o` is updated at every word load: it goes to 1 when the loaded word uses a reserved code and to 0 when it uses a legal one.
- R4: A frame starts only on a clock edge where `fsync_i` and `bit_en_i` are both 1 and no frame is in progress. From the next cycle, `sdata_oe_o` is 1 and `sdata_o` shows the first bit. A frame sync without `bit_en_i`, or one raised during a frame, has no effect.
- R5: A word-count input of value K makes a phase of K+1 words. With `dual_phase_i` = 0 the frame is phase one only, and `sdata_oe_o` falls at the edge that ends its last bit.
- R6: With `dual_phase_i` = 1 (sampled at frame start), phase-one words use `len_code1_i` and `word_cnt1_i`, and the phase-two words that follow use `len_code2_i` and `word_cnt2_i`. With `dual_phase_i` = 0, the phase-two inputs have no effect.
- R7: `word_end_o` goes to 1 at the `bit_en_i` edge that ends the last bit of a word. It stays 1 until the next `bit_en_i` edge, so there is one pulse per word.
- R8: `data_ready_o` is 1, combinationally, in exactly those `bit_en_i` cycles whose edge loads a word. `data_i` is taken at that edge when `data_valid_i` is 1.
- R9: A word load with `data_valid_i` = 0 sends the previously accepted word again and sets `underrun_o`. A load with valid data clears `underrun_o`. The previous word is 0 after reset.
- R10: In cycles with `bit_en_i` = 0, none of `sdata_o`, `sdata_oe_o` and `word_end_o` changes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_phase_i | input | 1 | 0: one phase per frame, 1: two phases |
| len_code1_i | input | 3 | Word-length code for phase one |
| len_code2_i | input | 3 | Word-length code for phase two |
| word_cnt1_i | input | CNT_W | Phase-one word count minus one |
| word_cnt2_i | input | CNT_W | Phase-two word count minus one |
| fsync_i | input | 1 | Frame-sync request |
| bit_en_i | input | 1 | Bit-clock enable; one bit per enabled cycle |
| data_i | input | DATA_W | Transmit word |
| data_valid_i | input | 1 | Transmit word is present |
| data_ready_o | output | 1 | Word is taken at this edge |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Serial data enable, 1 during a frame |
| word_end_o | output | 1 | Word-boundary strobe |
| code_err_o | output | 1 | Last loaded word used a reserved code |
| underrun_o | output | 1 | Last loaded word had no valid data |

## Verification
The bench keeps DATA_W at 32 and reduces CNT_W to 4. Every length code, including the full 32-bit width, can then be reached in frames of a few dozen to about a hundred and thirty bits. Narrow counts keep dual-phase frames with four and three words short enough to run bit-exact comparisons under both continuous and gapped bit-clock enables. The same bench also covers frame-sync noise during a frame, reserved codes in either phase and underrun repeats.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef logic [2:0] len_code_t;
  typedef logic [5:0] bit_cnt_t;

  typedef enum logic {PH_ONE = 1'b0, PH_TWO = 1'b1} phase_e;

  // Word width selected by a length code; reserved codes fall back to 8.
  function automatic bit_cnt_t fs_word_bits(input len_code_t code);
    bit_cnt_t n;
    case (code)
      3'd0:    n = 6'd8;
      3'd1:    n = 6'd12;
      3'd2:    n = 6'd16;
      3'd3:    n = 6'd20;
      3'd4:    n = 6'd24;
      3'd5:    n = 6'd32;
      default: n = 6'd8;
    endcase
    return n;
  endfunction

  function automatic logic fs_code_reserved(input len_code_t code);
    return code[2] & code[1];
  endfunction

endpackage

// File: rtl/fs_len_select.sv
module fs_len_select
  import fs_pkg::*;
(
  input  phase_e    phase_i,
  input  len_code_t code1_i,
  input  len_code_t code2_i,
  output bit_cnt_t  bits_o,
  output logic      reserved_o
);

  len_code_t codes   [2];
  bit_cnt_t  bits_arr[2];
  logic      rsv_arr [2];

  assign codes[0] = code1_i;
  assign codes[1] = code2_i;

  for (genvar p = 0; p < 2; p++) begin : g_phase
    assign bits_arr[p] = fs_word_bits(codes[p]);
    assign rsv_arr[p]  = fs_code_reserved(codes[p]);
  end

  assign bits_o     = (phase_i == PH_TWO) ? bits_arr[1] : bits_arr[0];
  assign reserved_o = (phase_i == PH_TWO) ? rsv_arr[1]  : rsv_arr[0];

endmodule

// File: rtl/fs_frame_seq.sv
module fs_frame_seq
  import fs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en_i,
  input  logic             fsync_i,
  input  logic             dual_i,
  input  logic [CNT_W-1:0] cnt1_i,
  input  logic [CNT_W-1:0] cnt2_i,
  input  logic             last_bit_i,
  output logic             active_o,
  output logic             start_evt_o,
  output logic             last_evt_o,
  output logic             load_evt_o,
  output phase_e           load_phase_o
);

  logic             active_q;
  logic             dual_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] cur_cnt;
  logic             phase_done;
  logic             frame_done;
  logic             next_evt;

  assign start_evt_o = bit_en_i & fsync_i & ~active_q;
  assign last_evt_o  = bit_en_i & active_q & last_bit_i;

  assign cur_cnt    = (phase_q == PH_TWO) ? cnt2_i : cnt1_i;
  assign phase_done = (idx_q == cur_cnt);
  assign frame_done = phase_done & ((phase_q == PH_TWO) | ~dual_q);
  assign next_evt   = last_evt_o & ~frame_done;

  assign load_evt_o   = start_evt_o | next_evt;
  assign load_phase_o = start_evt_o ? PH_ONE : (phase_done ? PH_TWO : phase_q);
  assign active_o     = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dual_q   <= 1'b0;
      phase_q  <= PH_ONE;
      idx_q    <= '0;
    end else if (start_evt_o) begin
      active_q <= 1'b1;
      dual_q   <= dual_i;
      phase_q  <= PH_ONE;
      idx_q    <= '0;
    end else if (next_evt) begin
      phase_q  <= load_phase_o;
      idx_q    <= phase_done ? '0 : idx_q + 1'b1;
    end else if (last_evt_o) begin
      active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/fs_shifter.sv
module fs_shifter #(
  parameter int DATA_W = 32,
  parameter int BITS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              sdata_o,
  output logic              last_bit_o,
  output logic              underrun_o
);

  localparam logic [BITS_W-1:0] FULL_W = BITS_W'(DATA_W);

  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] src;
  logic [BITS_W-1:0] left_q;
  logic [BITS_W-1:0] pad;
  logic              underrun_q;

  assign src = valid_i ? data_i : prev_q;
  assign pad = FULL_W - bits_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      prev_q     <= '0;
      left_q     <= '0;
      underrun_q <= 1'b0;
    end else if (load_i) begin
      shreg_q    <= src << pad;
      left_q     <= bits_i - 1'b1;
      underrun_q <= ~valid_i;
      if (valid_i) prev_q <= data_i;
    end else if (shift_i) begin
      shreg_q <= shreg_q << 1;
      left_q  <= left_q - 1'b1;
    end
  end

  assign sdata_o    = shreg_q[DATA_W-1];
  assign last_bit_o = (left_q == '0);
  assign underrun_o = underrun_q;

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import fs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_phase_i,
  input  logic [2:0]        len_code1_i,
  input  logic [2:0]        len_code2_i,
  input  logic [CNT_W-1:0]  word_cnt1_i,
  input  logic [CNT_W-1:0]  word_cnt2_i,
  input  logic              fsync_i,
  input  logic              bit_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              word_end_o,
  output logic              code_err_o,
  output logic              underrun_o
);

  localparam int BITS_W = $bits(bit_cnt_t);

  // Named internal events, visible to the bound checker.
  logic     active;
  logic     start_evt;
  logic     last_evt;
  logic     load_evt;
  logic     last_bit;
  logic     shift_evt;
  logic     sdata_raw;
  logic     load_rsv;
  phase_e   load_phase;
  bit_cnt_t load_bits;
  logic     word_end_q;
  logic     code_err_q;

  fs_frame_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en_i     (bit_en_i),
    .fsync_i      (fsync_i),
    .dual_i       (dual_phase_i),
    .cnt1_i       (word_cnt1_i),
    .cnt2_i       (word_cnt2_i),
    .last_bit_i   (last_bit),
    .active_o     (active),
    .start_evt_o  (start_evt),
    .last_evt_o   (last_evt),
    .load_evt_o   (load_evt),
    .load_phase_o (load_phase)
  );

  fs_len_select u_len (
    .phase_i    (load_phase),
    .code1_i    (len_code1_i),
    .code2_i    (len_code2_i),
    .bits_o     (load_bits),
    .reserved_o (load_rsv)
  );

  assign shift_evt = bit_en_i & active & ~last_bit;

  fs_shifter #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_evt),
    .shift_i    (shift_evt),
    .bits_i     (load_bits),
    .data_i     (data_i),
    .valid_i    (data_valid_i),
    .sdata_o    (sdata_raw),
    .last_bit_o (last_bit),
    .underrun_o (underrun_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_end_q <= 1'b0;
      code_err_q <= 1'b0;
    end else begin
      if (bit_en_i) word_end_q <= last_evt;
      if (load_evt) code_err_q <= load_rsv;
    end
  end

  assign data_ready_o = load_evt;
  assign sdata_o      = active & sdata_raw;
  assign sdata_oe_o   = active;
  assign word_end_o   = word_end_q;
  assign code_err_o   = code_err_q;

endmodule

// File: rtl/fs_checker.sv
module fs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en_i,
  input logic       fsync_i,
  input logic       data_valid_i,
  input logic [2:0] len_code1_i,
  input logic       data_ready_o,
  input logic       sdata_o,
  input logic       sdata_oe_o,
  input logic       word_end_o,
  input logic       code_err_o,
  input logic       underrun_o,
  input logic       start_evt,
  input logic       last_evt,
  input logic       last_bit
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe_o |-> !sdata_o);

  p_first_code_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (code_err_o == $past(len_code1_i[2] & len_code1_i[1])));

  p_start_needs_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe_o) |-> $past(fsync_i && bit_en_i));

  p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe_o && !last_bit) |=> sdata_oe_o);

  p_word_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> word_end_o);

  p_ready_on_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |-> bit_en_i);

  p_underrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready_o && !data_valid_i) |=> underrun_o);

  p_hold_without_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> ($stable(sdata_o) && $stable(sdata_oe_o) && $stable(word_end_o)));

endmodule

bind frame_serializer fs_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_en_i     (bit_en_i),
  .fsync_i      (fsync_i),
  .data_valid_i (data_valid_i),
  .len_code1_i  (len_code1_i),
  .data_ready_o (data_ready_o),
  .sdata_o      (sdata_o),
  .sdata_oe_o   (sdata_oe_o),
  .word_end_o   (word_end_o),
  .code_err_o   (code_err_o),
  .underrun_o   (underrun_o),
  .start_evt    (start_evt),
  .last_evt     (last_evt),
  .last_bit     (last_bit)
);

// File: tb/sim_frame_serializer.sv
module sim_frame_serializer;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int NVEC   = 8;

  // {dual, code1, code2, cnt1, cnt2, gap, fsync_noise, expected_bits}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 3'd6, 2'd0, 2'd0, 1'b0, 1'b0, 9'd8},
    {1'b0, 3'd1, 3'd0, 2'd2, 2'd0, 1'b0, 1'b1, 9'd36},
    {1'b1, 3'd2, 3'd3, 2'd1, 2'd0, 1'b0, 1'b0, 9'd52},
    {1'b1, 3'd4, 3'd5, 2'd0, 2'd1, 1'b1, 1'b0, 9'd88},
    {1'b0, 3'd5, 3'd0, 2'd1, 2'd0, 1'b1, 1'b0, 9'd64},
    {1'b1, 3'd6, 3'd0, 2'd1, 2'd0, 1'b0, 1'b0, 9'd24},
    {1'b0, 3'd7, 3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 9'd8},
    {1'b1, 3'd3, 3'd2, 2'd3, 2'd2, 1'b1, 1'b1, 9'd128}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dual_phase_i = 1'b0;
  logic [2:0]        len_code1_i = '0;
  logic [2:0]        len_code2_i = '0;
  logic [CNT_W-1:0]  word_cnt1_i = '0;
  logic [CNT_W-1:0]  word_cnt2_i = '0;
  logic              fsync_i = 1'b0;
  logic              bit_en_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              data_valid_i = 1'b0;
  logic              data_ready_o;
  logic              sdata_o;
  logic              sdata_oe_o;
  logic              word_end_o;
  logic              code_err_o;
  logic              underrun_o;

  int n_checks = 0;
  int n_fail   = 0;
  int n_cycles = 0;

  logic [DATA_W-1:0] last_sent = '0;
  logic              exp_bits [0:1023];
  logic [DATA_W-1:0] words    [0:15];

  always #4 clk = ~clk;

  frame_serializer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .dual_phase_i (dual_phase_i),
    .len_code1_i  (len_code1_i),
    .len_code2_i  (len_code2_i),
    .word_cnt1_i  (word_cnt1_i),
    .word_cnt2_i  (word_cnt2_i),
    .fsync_i      (fsync_i),
    .bit_en_i     (bit_en_i),
    .data_i       (data_i),
    .data_valid_i (data_valid_i),
    .data_ready_o (data_ready_o),
    .sdata_o      (sdata_o),
    .sdata_oe_o   (sdata_oe_o),
    .word_end_o   (word_end_o),
    .code_err_o   (code_err_o),
    .underrun_o   (underrun_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] c);
    if (c >= 3'd6) return 8;
    if (c == 3'd5) return 32;
    return 8 + 4 * int'(c);
  endfunction

  function automatic logic rsv_of(input logic [2:0] c);
    return (c == 3'd6) || (c == 3'd7);
  endfunction

  always @(posedge clk) begin
    n_cycles++;
    if (n_cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<150000", n_cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // Runs one frame and compares the captured stream with the bench model.
  task automatic run_frame(input logic dual, input logic [2:0] c1, input logic [2:0] c2,
                           input int n1, input int n2, input logic gap, input logic noise,
                           input logic [15:0] vmask, input int seed, input int tbl_bits,
                           input string tag);
    int exp_n = 0;
    int total = 0;
    int got = 0;
    int mism = 0;
    int we_pulses = 0;
    int rdy_cnt = 0;
    int widx = 0;
    int cyc = 0;
    logic started = 1'b0;
    logic prev_we;
    logic last_code_rsv = 1'b0;
    for (int i = 0; i < 16; i++)
      words[i] = 32'h9E3779B9 * (i + 1 + seed * 16) ^ 32'h5A5AC3C3;
    for (int ph = 0; ph < (dual ? 2 : 1); ph++) begin
      int cnt = (ph == 0) ? n1 : n2;
      logic [2:0] cd = (ph == 0) ? c1 : c2;
      for (int w = 0; w <= cnt; w++) begin
        logic [DATA_W-1:0] sent = vmask[total] ? words[total] : last_sent;
        last_sent = sent;
        for (int b = len_of(cd) - 1; b >= 0; b--) begin
          exp_bits[exp_n] = sent[b];
          exp_n++;
        end
        last_code_rsv = rsv_of(cd);
        total++;
      end
    end
    @(negedge clk);
    dual_phase_i = dual;
    len_code1_i  = c1;
    len_code2_i  = c2;
    word_cnt1_i  = CNT_W'(n1);
    word_cnt2_i  = CNT_W'(n2);
    fsync_i      = 1'b1;
    bit_en_i     = 1'b1;
    data_i       = words[0];
    data_valid_i = vmask[0];
    prev_we      = word_end_o;
    while (cyc < 5000) begin
      logic took = 1'b0;
      #1;
      if (bit_en_i && sdata_oe_o) begin
        if (got < 1024 && sdata_o !== exp_bits[got]) mism++;
        got++;
      end
      if (data_ready_o) begin
        rdy_cnt++;
        took = 1'b1;
      end
      @(posedge clk);
      if (took) widx++;
      @(negedge clk);
      cyc++;
      if (word_end_o && !prev_we) we_pulses++;
      prev_we = word_end_o;
      if (sdata_oe_o) started = 1'b1;
      if (started && !sdata_oe_o) break;
      fsync_i      = noise;
      bit_en_i     = gap ? ((cyc % 3) != 1) : 1'b1;
      data_i       = words[widx];
      data_valid_i = vmask[widx];
    end
    fsync_i      = 1'b0;
    bit_en_i     = 1'b0;
    data_valid_i = 1'b0;
    check(dual ? "R6" : "R2", {tag, " bit mismatches"}, 64'(mism), 64'd0);
    check("R5", {tag, " bits sent"}, 64'(got), 64'(exp_n));
    if (tbl_bits > 0) check("R5", {tag, " bits vs table"}, 64'(got), 64'(tbl_bits));
    check("R7", {tag, " word-end pulses"}, 64'(we_pulses), 64'(total));
    check("R8", {tag, " ready cycles"}, 64'(rdy_cnt), 64'(total));
    check("R3", {tag, " code error flag"}, 64'(code_err_o), 64'(last_code_rsv));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "oe in reset", 64'(sdata_oe_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sdata after reset", 64'(sdata_o), 64'd0);
    check("R1", "oe after reset", 64'(sdata_oe_o), 64'd0);
    check("R1", "word_end after reset", 64'(word_end_o), 64'd0);
    check("R1", "code_err after reset", 64'(code_err_o), 64'd0);
    check("R1", "underrun after reset", 64'(underrun_o), 64'd0);
    check("R1", "ready after reset", 64'(data_ready_o), 64'd0);

    // R4: frame sync without a bit-clock enable starts nothing
    fsync_i = 1'b1;
    repeat (3) @(negedge clk);
    fsync_i = 1'b0;
    check("R4", "sync without enable", 64'(sdata_oe_o), 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [21:0] e = VEC[v];
      run_frame(e[21], e[20:18], e[17:15], int'(e[14:13]), int'(e[12:11]),
                e[10], e[9], 16'hFFFF, v, int'(e[8:0]), $sformatf("vec%0d", v));
    end

    // R7 / R10: strobe holds while bit clock is idle, clears at next enable
    repeat (3) @(negedge clk);
    check("R10", "word_end held without enable", 64'(word_end_o), 64'd1);
    bit_en_i = 1'b1;
    @(negedge clk);
    bit_en_i = 1'b0;
    check("R7", "word_end cleared after enable", 64'(word_end_o), 64'd0);
    check("R4", "idle after frame", 64'(sdata_oe_o), 64'd0);

    // R9: second word missing, previous word repeated
    run_frame(1'b0, 3'd0, 3'd0, 1, 0, 1'b0, 1'b0, 16'h0001, 20, 16, "underrun");
    check("R9", "underrun flag set", 64'(underrun_o), 64'd1);
    run_frame(1'b0, 3'd2, 3'd0, 0, 0, 1'b0, 1'b0, 16'hFFFF, 21, 16, "recover");
    check("R9", "underrun flag cleared", 64'(underrun_o), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule